// File: doc/BRIEF.md
# Replay Region Boundary Hint Recorder

Each core of a multiprocessor that records execution for later deterministic replay gets one copy of this block. It splits the recorded run into regions that follow one global order. Offline analysis can then rebuild the ordering of shared accesses one region at a time, and the end state of each region is the start state of the next. At every region boundary the block emits one hint record. The record holds the region's sequence number and the number of memory operations the core has retired since recording was switched on.

Two boundary policies are available. With the periodic policy, a boundary fires every P enabled cycles. Each core counts on its own and needs nothing from the other cores. With the downgrade policy, the block counts coherence downgrade requests that reach the core. When T of them have arrived since the last boundary, a boundary fires and is broadcast to the other cores. A boundary that arrives on the broadcast input forces a record on this core too, so every core closes the region together. The policy, P and T sit in configuration registers. These registers accept writes only while recording is off.

Top module: `region_hint_rec`

## Requirements
- R1: After synchronous reset, `hint_vld` and `bcast_out` are 0, the policy is periodic (`cfg_mode` code 0), the period is `DEF_PERIOD` and the threshold is `DEF_THRESH`.
- R2: A configuration write (`cfg_we` high) is accepted at the clock edge only when `rec_en` is low. A write while `rec_en` is high changes nothing.
- R3: In periodic mode (`cfg_mode` = 0), a boundary fires in the P-th enabled cycle counted from the enable or from the previous boundary. Its record appears on `hint_vld` one clock later.
- R4: In periodic mode, `dgr_req` and `bcast_in` have no effect and `bcast_out` stays 0.
- R5: In downgrade mode (`cfg_mode` = 1), a boundary fires in the cycle that carries the T-th `dgr_req` strobe since the last boundary. One clock later `bcast_out` pulses together with `hint_vld`.
- R6: In downgrade mode with `rec_en` high, `bcast_in` forces a boundary and clears the local downgrade count. That record is not echoed on `bcast_out`.
- R7: When a local threshold crossing and `bcast_in` fall in the same cycle, the block produces exactly one record.
- R8: `hint_cnt` equals the number of `memop_ret` strobes from the cycle `rec_en` went high up to and including the boundary cycle. `hint_seq` is 0 for the first record after enable and rises by 1 with each record.
- R9: While `rec_en` is low, no record is produced and the strobes are ignored. The operation count, the sequence number and the boundary counters all return to zero.
- R10: A period or threshold written as 0 is stored as 1, so a boundary fires on every qualifying cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_en | input | 1 | Recording enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 1 | Policy: 0 periodic, 1 downgrade |
| cfg_period | input | CYC_W | Boundary period in cycles |
| cfg_thresh | input | DG_W | Downgrade count per region |
| memop_ret | input | 1 | Memory operation retired this cycle |
| dgr_req | input | 1 | Coherence downgrade request this cycle |
| bcast_in | input | 1 | Boundary announced by another core |
| bcast_out | output | 1 | Boundary announced to other cores |
| hint_vld | output | 1 | Hint record valid |
| hint_seq | output | SEQ_W | Region sequence number |
| hint_cnt | output | CNT_W | Memory operation count at the boundary |

## Verification
On every cycle the assertions check four things. A record never follows a cycle with recording off. A broadcast pulse always comes with a record and follows a downgrade strobe in downgrade mode. The configuration holds steady while recording runs. Successive records in one enable session step their sequence number by one. The bench's scenarios cover what depends on counting across many cycles: the exact period and threshold spacing, the clearing of the count by an incoming broadcast, the single record on a coincident crossing and broadcast, ignored writes, and the handling of zero settings.

// File: rtl/rhr_pkg.sv
package rhr_pkg;
  typedef enum logic {
    MODE_CYCLE     = 1'b0,
    MODE_DOWNGRADE = 1'b1
  } bound_mode_e;
endpackage

// File: rtl/rhr_cfg.sv
module rhr_cfg
  import rhr_pkg::*;
#(
  parameter int CYC_W      = 16,
  parameter int DG_W       = 8,
  parameter int DEF_PERIOD = 10000,
  parameter int DEF_THRESH = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rec_en,
  input  logic              cfg_we,
  input  logic              cfg_mode,
  input  logic [CYC_W-1:0]  cfg_period,
  input  logic [DG_W-1:0]   cfg_thresh,
  output bound_mode_e       mode_q,
  output logic [CYC_W-1:0]  period_q,
  output logic [DG_W-1:0]   thresh_q
);
  localparam logic [CYC_W-1:0] PER_RST = CYC_W'(DEF_PERIOD);
  localparam logic [DG_W-1:0]  THR_RST = DG_W'(DEF_THRESH);
  localparam logic [CYC_W-1:0] PER_MIN = CYC_W'(1);
  localparam logic [DG_W-1:0]  THR_MIN = DG_W'(1);

  logic wr_ok;
  assign wr_ok = cfg_we && !rec_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_CYCLE;
      period_q <= PER_RST;
      thresh_q <= THR_RST;
    end else if (wr_ok) begin
      mode_q   <= bound_mode_e'(cfg_mode);
      period_q <= (cfg_period == '0) ? PER_MIN : cfg_period;
      thresh_q <= (cfg_thresh == '0) ? THR_MIN : cfg_thresh;
    end
  end
endmodule

// File: rtl/rhr_trigger.sv
module rhr_trigger
  import rhr_pkg::*;
#(
  parameter int CYC_W = 16,
  parameter int DG_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rec_en,
  input  bound_mode_e      mode,
  input  logic [CYC_W-1:0] period,
  input  logic [DG_W-1:0]  thresh,
  input  logic             dgr_req,
  input  logic             bcast_in,
  output logic             fire,
  output logic             local_dg
);
  logic [CYC_W-1:0] cyc_q;
  logic [DG_W-1:0]  dg_q;
  logic             in_cyc, in_dg;
  logic             cyc_hit, dg_hit, bc_hit;

  assign in_cyc   = (mode == MODE_CYCLE);
  assign in_dg    = (mode == MODE_DOWNGRADE);
  assign cyc_hit  = in_cyc && (cyc_q == period - CYC_W'(1));
  assign dg_hit   = in_dg && dgr_req && (dg_q == thresh - DG_W'(1));
  assign bc_hit   = in_dg && bcast_in;
  assign fire     = rec_en && (cyc_hit || dg_hit || bc_hit);
  assign local_dg = rec_en && dg_hit;

  always_ff @(posedge clk) begin
    if (rst || !rec_en || fire) begin
      cyc_q <= '0;
      dg_q  <= '0;
    end else begin
      if (in_cyc)            cyc_q <= cyc_q + CYC_W'(1);
      if (in_dg && dgr_req)  dg_q  <= dg_q + DG_W'(1);
    end
  end
endmodule

// File: rtl/rhr_logger.sv
module rhr_logger #(
  parameter int CNT_W = 32,
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rec_en,
  input  logic             memop_ret,
  input  logic             fire,
  input  logic             local_dg,
  output logic             hint_vld,
  output logic [SEQ_W-1:0] hint_seq,
  output logic [CNT_W-1:0] hint_cnt,
  output logic             bcast_out
);
  logic [CNT_W-1:0] ops_q, ops_next;
  logic [SEQ_W-1:0] seq_q;

  assign ops_next = ops_q + CNT_W'(memop_ret);

  always_ff @(posedge clk) begin
    if (rst) begin
      ops_q     <= '0;
      seq_q     <= '0;
      hint_vld  <= 1'b0;
      bcast_out <= 1'b0;
      hint_seq  <= '0;
      hint_cnt  <= '0;
    end else if (!rec_en) begin
      ops_q     <= '0;
      seq_q     <= '0;
      hint_vld  <= 1'b0;
      bcast_out <= 1'b0;
    end else begin
      ops_q     <= ops_next;
      hint_vld  <= fire;
      bcast_out <= local_dg;
      if (fire) begin
        seq_q    <= seq_q + SEQ_W'(1);
        hint_seq <= seq_q;
        hint_cnt <= ops_next;
      end
    end
  end
endmodule

// File: rtl/region_hint_rec.sv
module region_hint_rec
  import rhr_pkg::*;
#(
  parameter int CYC_W      = 16,
  parameter int DG_W       = 8,
  parameter int CNT_W      = 32,
  parameter int SEQ_W      = 16,
  parameter int DEF_PERIOD = 10000,
  parameter int DEF_THRESH = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rec_en,
  input  logic             cfg_we,
  input  logic             cfg_mode,
  input  logic [CYC_W-1:0] cfg_period,
  input  logic [DG_W-1:0]  cfg_thresh,
  input  logic             memop_ret,
  input  logic             dgr_req,
  input  logic             bcast_in,
  output logic             bcast_out,
  output logic             hint_vld,
  output logic [SEQ_W-1:0] hint_seq,
  output logic [CNT_W-1:0] hint_cnt
);
  bound_mode_e      mode_q;
  logic [CYC_W-1:0] period_q;
  logic [DG_W-1:0]  thresh_q;
  logic             fire, local_dg;

  rhr_cfg #(
    .CYC_W(CYC_W), .DG_W(DG_W), .DEF_PERIOD(DEF_PERIOD), .DEF_THRESH(DEF_THRESH)
  ) u_cfg (
    .clk(clk), .rst(rst), .rec_en(rec_en), .cfg_we(cfg_we),
    .cfg_mode(cfg_mode), .cfg_period(cfg_period), .cfg_thresh(cfg_thresh),
    .mode_q(mode_q), .period_q(period_q), .thresh_q(thresh_q)
  );

  rhr_trigger #(.CYC_W(CYC_W), .DG_W(DG_W)) u_trig (
    .clk(clk), .rst(rst), .rec_en(rec_en), .mode(mode_q),
    .period(period_q), .thresh(thresh_q), .dgr_req(dgr_req),
    .bcast_in(bcast_in), .fire(fire), .local_dg(local_dg)
  );

  rhr_logger #(.CNT_W(CNT_W), .SEQ_W(SEQ_W)) u_log (
    .clk(clk), .rst(rst), .rec_en(rec_en), .memop_ret(memop_ret),
    .fire(fire), .local_dg(local_dg), .hint_vld(hint_vld),
    .hint_seq(hint_seq), .hint_cnt(hint_cnt), .bcast_out(bcast_out)
  );
endmodule

// File: rtl/rhr_checker.sv
module rhr_checker
  import rhr_pkg::*;
#(
  parameter int CYC_W = 16,
  parameter int DG_W  = 8,
  parameter int SEQ_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             rec_en,
  input logic             dgr_req,
  input logic             hint_vld,
  input logic             bcast_out,
  input logic [SEQ_W-1:0] hint_seq,
  input bound_mode_e      mode_q,
  input logic [CYC_W-1:0] period_q,
  input logic [DG_W-1:0]  thresh_q
);
  logic             have_prev;
  logic [SEQ_W-1:0] last_seq;

  always_ff @(posedge clk) begin
    if (rst || !rec_en) begin
      have_prev <= 1'b0;
      last_seq  <= '0;
    end else if (hint_vld) begin
      have_prev <= 1'b1;
      last_seq  <= hint_seq;
    end
  end

  p_vld_needs_en_r9: assert property (@(posedge clk) disable iff (rst)
    hint_vld |-> $past(rec_en));

  p_bcast_from_dgr_r5: assert property (@(posedge clk) disable iff (rst)
    bcast_out |-> (hint_vld && $past(dgr_req) && $past(rec_en)));

  p_bcast_quiet_cycle_r4: assert property (@(posedge clk) disable iff (rst)
    bcast_out |-> $past(mode_q) == MODE_DOWNGRADE);

  p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(rec_en) && !$past(rst)) |->
      ($stable(period_q) && $stable(thresh_q) && $stable(mode_q)));

  p_seq_step_r8: assert property (@(posedge clk) disable iff (rst)
    (hint_vld && rec_en && have_prev) |-> hint_seq == last_seq + SEQ_W'(1));
endmodule

bind region_hint_rec rhr_checker #(.CYC_W(CYC_W), .DG_W(DG_W), .SEQ_W(SEQ_W)) u_chk (
  .clk(clk), .rst(rst), .rec_en(rec_en), .dgr_req(dgr_req),
  .hint_vld(hint_vld), .bcast_out(bcast_out), .hint_seq(hint_seq),
  .mode_q(mode_q), .period_q(period_q), .thresh_q(thresh_q)
);

// File: tb/sim_region_hint_rec.sv
module sim_region_hint_rec;
  localparam int CLK_PERIOD = 10;
  localparam int CYC_W = 16, DG_W = 8, CNT_W = 32, SEQ_W = 16;
  localparam int DEF_PERIOD = 10000, DEF_THRESH = 25;

  logic clk = 1'b0;
  logic rst = 1'b1, rec_en = 1'b0, cfg_we = 1'b0, cfg_mode = 1'b0;
  logic [CYC_W-1:0] cfg_period = '0;
  logic [DG_W-1:0]  cfg_thresh = '0;
  logic memop_ret = 1'b0, dgr_req = 1'b0, bcast_in = 1'b0;
  logic bcast_out, hint_vld;
  logic [SEQ_W-1:0] hint_seq;
  logic [CNT_W-1:0] hint_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  region_hint_rec #(
    .CYC_W(CYC_W), .DG_W(DG_W), .CNT_W(CNT_W), .SEQ_W(SEQ_W),
    .DEF_PERIOD(DEF_PERIOD), .DEF_THRESH(DEF_THRESH)
  ) u0 (
    .clk(clk), .rst(rst), .rec_en(rec_en), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_period(cfg_period), .cfg_thresh(cfg_thresh), .memop_ret(memop_ret),
    .dgr_req(dgr_req), .bcast_in(bcast_in), .bcast_out(bcast_out),
    .hint_vld(hint_vld), .hint_seq(hint_seq), .hint_cnt(hint_cnt)
  );

  int total = 0, bad = 0;
  bit done = 0;
  // behavioural reference state
  int m_mode, m_per, m_thr, m_cyc, m_dg, m_ops, m_seq;
  bit e_vld, e_bo;
  int e_seq, e_cnt;
  // observation counters
  int nh = 0, nbo = 0, last_seq = -1, last_cnt = -1;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_edge();
    bit lc, ld, lb, f;
    if (rst) begin
      m_mode = 0; m_per = DEF_PERIOD; m_thr = DEF_THRESH;
      m_cyc = 0; m_dg = 0; m_ops = 0; m_seq = 0;
      e_vld = 0; e_bo = 0; e_seq = 0; e_cnt = 0;
    end else if (!rec_en) begin
      m_cyc = 0; m_dg = 0; m_ops = 0; m_seq = 0; e_vld = 0; e_bo = 0;
      if (cfg_we) begin
        m_mode = cfg_mode;
        m_per = (cfg_period == 0) ? 1 : int'(cfg_period);
        m_thr = (cfg_thresh == 0) ? 1 : int'(cfg_thresh);
      end
    end else begin
      lc = (m_mode == 0) && (m_cyc == m_per - 1);
      ld = (m_mode == 1) && dgr_req && (m_dg == m_thr - 1);
      lb = (m_mode == 1) && bcast_in;
      f = lc || ld || lb;
      m_ops += memop_ret;
      e_vld = f; e_bo = ld;
      if (f) begin
        e_seq = m_seq; e_cnt = m_ops; m_seq++; m_cyc = 0; m_dg = 0;
      end else begin
        if (m_mode == 0) m_cyc++;
        if (m_mode == 1 && dgr_req) m_dg++;
      end
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R3 hint_vld", int'(hint_vld), int'(e_vld));
    chk("R5 bcast_out", int'(bcast_out), int'(e_bo));
    if (e_vld && hint_vld) begin
      chk("R8 hint_seq", int'(hint_seq), e_seq);
      chk("R8 hint_cnt", int'(hint_cnt), e_cnt);
    end
    if (hint_vld) begin
      nh++; last_seq = int'(hint_seq); last_cnt = int'(hint_cnt);
    end
    if (bcast_out) nbo++;
  endtask

  task automatic drive(bit r, bit d, bit b);
    memop_ret = r; dgr_req = d; bcast_in = b;
    step();
  endtask

  task automatic write_cfg(bit md, int per, int thr);
    rec_en = 0; cfg_we = 1; cfg_mode = md;
    cfg_period = CYC_W'(per); cfg_thresh = DG_W'(thr);
    drive(0, 0, 0);
    cfg_we = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int h0, b0;
    @(negedge clk);
    rst = 1; repeat (3) drive(0, 0, 0);
    rst = 0;
    chk("R1 hint_vld after reset", int'(hint_vld), 0);
    chk("R1 bcast_out after reset", int'(bcast_out), 0);
    // R1 defaults: periodic mode, long period -> no boundary in 30 cycles
    rec_en = 1; nh = 0;
    for (int i = 0; i < 30; i++) drive(1, 1, 0);
    chk("R1 default config no boundary", nh, 0);
    rec_en = 0; drive(0, 0, 0);

    // R3 / R4: period 5 with stray downgrade and broadcast strobes
    write_cfg(0, 5, 4);
    rec_en = 1; nh = 0; nbo = 0;
    for (int i = 0; i < 23; i++) drive(i % 3 != 0, i % 4 == 0, i % 7 == 0);
    chk("R3 periodic boundaries", nh, 4);
    chk("R4 no broadcast in periodic mode", nbo, 0);

    // R9: disabled strobes have no effect
    rec_en = 0; nh = 0;
    for (int i = 0; i < 5; i++) drive(1, 1, 1);
    chk("R9 no records while disabled", nh, 0);

    // R2: write while enabled is ignored (period stays 5, mode stays periodic)
    rec_en = 1; cfg_we = 1; cfg_mode = 1; cfg_period = 2; cfg_thresh = 1;
    nh = 0; nbo = 0;
    drive(0, 1, 0);
    cfg_we = 0;
    for (int i = 0; i < 9; i++) drive(0, 1, 0);
    chk("R2 write while enabled ignored", nh, 2);
    chk("R2 mode unchanged", nbo, 0);

    // R5: downgrade mode, threshold 3, 7 strobes
    write_cfg(1, 100, 3);
    rec_en = 1; nh = 0; nbo = 0;
    for (int i = 0; i < 14; i++) drive(1, i % 2 == 0, 0);
    chk("R5 downgrade boundaries", nh, 2);
    chk("R5 broadcast pulses", nbo, 2);

    // R6: broadcast forces record and clears count (count was 1)
    h0 = nh; b0 = nbo;
    drive(0, 0, 1);
    drive(0, 1, 0); drive(0, 0, 0); drive(0, 1, 0); drive(0, 0, 0);
    chk("R6 forced record only", nh - h0, 1);
    chk("R6 no echo broadcast", nbo - b0, 0);

    // R7: count is 2, crossing and broadcast together -> one record
    h0 = nh; b0 = nbo;
    drive(0, 1, 1);
    drive(0, 0, 0); drive(0, 0, 0);
    chk("R7 single record on coincidence", nh - h0, 1);
    chk("R7 local crossing broadcast", nbo - b0, 1);

    // R8: fresh session, first record seq 0, count includes boundary cycle
    rec_en = 0; drive(0, 0, 0);
    rec_en = 1;
    drive(1, 0, 0); drive(1, 0, 0); drive(1, 0, 0); drive(1, 0, 1);
    chk("R8 first seq after enable", last_seq, 0);
    chk("R8 op count at boundary", last_cnt, 4);
    drive(1, 0, 1);
    chk("R8 seq increments", last_seq, 1);
    chk("R8 op count accumulates", last_cnt, 5);

    // R10: zero period and threshold stored as one
    write_cfg(0, 0, 0);
    rec_en = 1; nh = 0;
    for (int i = 0; i < 6; i++) drive(0, 0, 0);
    chk("R10 zero period fires each cycle", nh, 6);
    write_cfg(1, 0, 0);
    rec_en = 1; nh = 0; nbo = 0;
    for (int i = 0; i < 4; i++) drive(0, 1, 0);
    chk("R10 zero threshold fires each strobe", nbo, 4);

    rec_en = 0; drive(0, 0, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule